// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Event Code

This block collects a set of level interrupt requests and reduces them to one request line for a parent controller. Each source can be blocked by a mask bit and carries a 4-bit priority. Priority zero disables a source. Several sources may share one priority field, which forms a group. A read-only event-code register returns the vector code of the source that should be serviced next. Software uses this code to find the source.

Software reaches the block over a small register bus. It has a write strobe, a read strobe, an 8-bit byte address and 32-bit data. Read data appears one cycle after the read strobe. Every mask bank has two addresses, one to set mask bits and one to clear them, so no read-modify-write is needed. Parameters give the number of sources, the number of mask banks and priority registers, and the mapping from each source to its mask bit and priority field.

Top module: `pic_event_ctrl`

## Requirements
- R1: After reset every implemented mask bit is 1 (masked), every priority field is 0, `irq_out` is 0 and the event code reads 0.
- R2: A write to address 0x00+4*b sets mask bit j of bank b for every 1 in `bus_wdata[j]`, j in 0..7. Mask bits whose data bit is 0 keep their value. Reading either bank address returns the 8 mask bits in `bus_rdata[7:0]`.
- R3: A write to address 0x40+4*b clears mask bit j of bank b for every 1 in `bus_wdata[j]`. Mask bits whose data bit is 0 keep their value.
- R4: Address 0x80+4*p holds priority register p. Bits 4f+3:4f of that register are priority field 4p+f, f in 0..3. A write stores `bus_wdata[15:0]`. A read returns the stored value in `bus_rdata[15:0]`.
- R5: A mask bit with no source mapped to it, and a priority field with no source mapped to it, always read 0. Writes to them have no effect.
- R6: `irq_out` is 1 exactly when at least one source has its request high, is unmasked, and has a nonzero priority. It follows a change of any of these one clock cycle later.
- R7: A source whose priority field is 0 never raises `irq_out` and never appears in the event code, even when it is unmasked and requesting.
- R8: The event code at address 0xC0 (`bus_rdata[15:0]`) is 0x0600 + 0x20*i, where i is the qualifying source with the highest priority value.
- R9: If qualifying sources share the highest priority value, the one with the lowest source index wins.
- R10: When no source qualifies, the event code reads 0.
- R11: All sources mapped to one priority field take their priority from that single field. One write changes the priority of the whole group.
- R12: With default parameters, sources 0 to 11 use mask bits 0,1,2,3,4,6,8,9,10,12,14,15 and priority fields 0,1,2,2,2,3,4,5,5,6,7,9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_req | input | NUM_SRC | Level requests from the sources |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| irq_out | output | 1 | Combined request to the parent controller |

## Verification
Two functions can act in the same cycle. A mask or priority write can land in the cycle where a request changes, and arbitration then has to resolve sources that were just enabled. The bench provokes this by unmasking or re-prioritising a source while other sources are already requesting. After the one-cycle pipeline it reads the event code and compares it with a model that applies the write rules and picks the winner by priority value, using the lowest index to break ties. Group writes and ties are judged the same way, so a single write that reorders several sources at once is checked against the expected winner.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int unsigned BANK_W       = 8;
  localparam int unsigned PREG_W       = 16;
  localparam int unsigned FIELD_W      = 4;
  localparam int unsigned FIELDS_PER_R = PREG_W / FIELD_W;
  localparam int unsigned MAP_W        = 8;

  typedef enum logic [1:0] {
    RGN_MSET = 2'd0,
    RGN_MCLR = 2'd1,
    RGN_PRIO = 2'd2,
    RGN_EVT  = 2'd3
  } region_e;

  // source index 11 first, index 0 last
  localparam logic [12*MAP_W-1:0] DEF_MASK_POS = {
    8'd15, 8'd14, 8'd12, 8'd10, 8'd9, 8'd8,
    8'd6,  8'd4,  8'd3,  8'd2,  8'd1, 8'd0};
  localparam logic [12*MAP_W-1:0] DEF_PRIO_FLD = {
    8'd9, 8'd7, 8'd6, 8'd5, 8'd5, 8'd4,
    8'd3, 8'd2, 8'd2, 8'd2, 8'd1, 8'd0};

  function automatic logic [15:0] vec_code(logic [15:0] base, logic [15:0] step,
                                           int unsigned idx);
    return base + 16'(step * 16'(idx));
  endfunction

  function automatic region_e addr_region(logic [7:0] a);
    return region_e'(a[7:6]);
  endfunction
endpackage

// File: rtl/pic_mask_bank.sv
module pic_mask_bank #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] IMPL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_we,
  input  logic         clr_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] mask
);
  logic [W-1:0] set_bits, clr_bits, nxt;

  always_comb begin
    set_bits = set_we ? wdata : '0;
    clr_bits = clr_we ? wdata : '0;
    nxt      = ((mask | set_bits) & ~clr_bits) & IMPL;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask <= IMPL;
    else        mask <= nxt;
  end
endmodule

// File: rtl/pic_prio_reg.sv
module pic_prio_reg #(
  parameter int unsigned W = 16,
  parameter logic [W-1:0] IMPL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= wdata & IMPL;
  end
endmodule

// File: rtl/pic_arbiter.sv
module pic_arbiter #(
  parameter int unsigned NUM_SRC = 12,
  parameter int unsigned FW      = 4,
  localparam int unsigned IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic [NUM_SRC-1:0]         src_req,
  input  logic [NUM_SRC-1:0]         src_masked,
  input  logic [NUM_SRC-1:0][FW-1:0] src_prio,
  output logic [NUM_SRC-1:0]         cand,
  output logic                       win_valid,
  output logic [IDX_W-1:0]           win_idx,
  output logic [FW-1:0]              win_prio
);
  always_comb begin
    for (int i = 0; i < NUM_SRC; i++)
      cand[i] = src_req[i] && !src_masked[i] && (src_prio[i] != '0);
  end

  // strict compare keeps the lowest index among equal priorities
  always_comb begin
    win_valid = 1'b0;
    win_idx   = '0;
    win_prio  = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (cand[i] && (src_prio[i] > win_prio)) begin
        win_valid = 1'b1;
        win_idx   = IDX_W'(i);
        win_prio  = src_prio[i];
      end
    end
  end
endmodule

// File: rtl/pic_event_ctrl.sv
module pic_event_ctrl #(
  parameter int unsigned NUM_SRC  = 12,
  parameter int unsigned NUM_BANK = 2,
  parameter int unsigned NUM_PREG = 3,
  parameter logic [15:0] VEC_BASE = 16'h0600,
  parameter logic [15:0] VEC_STEP = 16'h0020,
  parameter logic [NUM_SRC*8-1:0] MASK_POS = pic_pkg::DEF_MASK_POS,
  parameter logic [NUM_SRC*8-1:0] PRIO_FLD = pic_pkg::DEF_PRIO_FLD
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_req,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [7:0]         bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               irq_out
);
  import pic_pkg::*;

  localparam int unsigned MASK_BITS = NUM_BANK * BANK_W;
  localparam int unsigned PRIO_BITS = NUM_PREG * PREG_W;
  localparam int unsigned IDX_W     = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  function automatic logic [MASK_BITS-1:0] calc_mask_impl();
    logic [MASK_BITS-1:0] r = '0;
    for (int i = 0; i < NUM_SRC; i++)
      r[int'(MASK_POS[i*MAP_W +: MAP_W])] = 1'b1;
    return r;
  endfunction

  function automatic logic [PRIO_BITS-1:0] calc_prio_impl();
    logic [PRIO_BITS-1:0] r = '0;
    for (int i = 0; i < NUM_SRC; i++)
      r[int'(PRIO_FLD[i*MAP_W +: MAP_W])*FIELD_W +: FIELD_W] = '1;
    return r;
  endfunction

  localparam logic [MASK_BITS-1:0] MASK_IMPL = calc_mask_impl();
  localparam logic [PRIO_BITS-1:0] PRIO_IMPL = calc_prio_impl();

  // address decode
  region_e    rgn;
  logic [3:0] sel;
  logic       word_ok;
  logic       unused_bits;

  assign rgn         = addr_region(bus_addr);
  assign sel         = bus_addr[5:2];
  assign word_ok     = (bus_addr[1:0] == 2'b00);
  assign unused_bits = ^{bus_wdata[31:16]};

  // mask banks
  logic [MASK_BITS-1:0] mask_vec;
  logic [MASK_BITS-1:0] impl_mask;
  assign impl_mask = MASK_IMPL;

  for (genvar b = 0; b < NUM_BANK; b++) begin : g_bank
    logic hit;
    assign hit = bus_wr && word_ok && (sel == 4'(b));
    pic_mask_bank #(
      .W(BANK_W),
      .IMPL(MASK_IMPL[b*BANK_W +: BANK_W])
    ) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_we (hit && (rgn == RGN_MSET)),
      .clr_we (hit && (rgn == RGN_MCLR)),
      .wdata  (bus_wdata[BANK_W-1:0]),
      .mask   (mask_vec[b*BANK_W +: BANK_W])
    );
  end

  // priority registers
  logic [PRIO_BITS-1:0] prio_vec;

  for (genvar p = 0; p < NUM_PREG; p++) begin : g_preg
    pic_prio_reg #(
      .W(PREG_W),
      .IMPL(PRIO_IMPL[p*PREG_W +: PREG_W])
    ) u_preg (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (bus_wr && word_ok && (rgn == RGN_PRIO) && (sel == 4'(p))),
      .wdata (bus_wdata[PREG_W-1:0]),
      .q     (prio_vec[p*PREG_W +: PREG_W])
    );
  end

  // per-source view
  logic [NUM_SRC-1:0]              src_masked;
  logic [NUM_SRC-1:0][FIELD_W-1:0] src_prio;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    localparam int MPOS = int'(MASK_POS[i*MAP_W +: MAP_W]);
    localparam int FPOS = int'(PRIO_FLD[i*MAP_W +: MAP_W]);
    assign src_masked[i] = mask_vec[MPOS];
    assign src_prio[i]   = prio_vec[FPOS*FIELD_W +: FIELD_W];
  end

  // arbitration
  logic [NUM_SRC-1:0] cand;
  logic               win_valid;
  logic [IDX_W-1:0]   win_idx;
  logic [FIELD_W-1:0] win_prio;

  pic_arbiter #(.NUM_SRC(NUM_SRC), .FW(FIELD_W)) u_arb (
    .src_req    (src_req),
    .src_masked (src_masked),
    .src_prio   (src_prio),
    .cand       (cand),
    .win_valid  (win_valid),
    .win_idx    (win_idx),
    .win_prio   (win_prio)
  );

  logic [15:0] evt_q;
  logic        irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= win_valid;
      evt_q <= win_valid ? vec_code(VEC_BASE, VEC_STEP, int'(win_idx)) : 16'h0000;
    end
  end

  assign irq_out = irq_q;

  // read path
  logic [31:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    if (word_ok) begin
      unique case (rgn)
        RGN_MSET, RGN_MCLR: begin
          for (int b = 0; b < NUM_BANK; b++)
            if (sel == 4'(b)) rd_mux = {24'h0, mask_vec[b*BANK_W +: BANK_W]};
        end
        RGN_PRIO: begin
          for (int p = 0; p < NUM_PREG; p++)
            if (sel == 4'(p)) rd_mux = {16'h0, prio_vec[p*PREG_W +: PREG_W]};
        end
        RGN_EVT:  rd_mux = (sel == 4'd0) ? {16'h0, evt_q} : 32'h0;
        default:  rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/pic_event_ctrl_chk.sv
module pic_event_ctrl_chk #(
  parameter int unsigned NUM_SRC   = 12,
  parameter int unsigned MASK_BITS = 16,
  parameter int unsigned IDX_W     = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bus_wr,
  input logic [7:0]           bus_addr,
  input logic [7:0]           bus_wd8,
  input logic                 irq_out,
  input logic [MASK_BITS-1:0] mask_vec,
  input logic [MASK_BITS-1:0] impl_mask,
  input logic [NUM_SRC-1:0]   cand,
  input logic                 win_valid,
  input logic [IDX_W-1:0]     win_idx,
  input logic [3:0]           win_prio,
  input logic [15:0]          evt_q
);
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (!irq_out && evt_q == 16'h0)); // R1

  AST_MASK_SET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 8'h00) |=>
      ((mask_vec[7:0] & $past(bus_wd8) & impl_mask[7:0]) ==
       ($past(bus_wd8) & impl_mask[7:0]))); // R2

  AST_MASK_CLR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 8'h40) |=>
      ((mask_vec[7:0] & $past(bus_wd8)) == 8'h00)); // R3

  AST_UNUSED_MASK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_vec & ~impl_mask) == '0); // R5

  AST_IRQ_FOLLOWS_CAND: assert property (@(posedge clk) disable iff (!rst_n)
    (cand != '0) |=> irq_out); // R6

  AST_IRQ_DROPS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cand == '0) |=> !irq_out); // R6

  AST_WIN_PRIO_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> (win_prio != 4'h0)); // R7

  AST_WINNER_QUALIFIES: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> cand[win_idx]); // R8

  AST_IDLE_CODE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_out |-> (evt_q == 16'h0)); // R10
endmodule

bind pic_event_ctrl pic_event_ctrl_chk #(
  .NUM_SRC(NUM_SRC), .MASK_BITS(MASK_BITS), .IDX_W(IDX_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wd8   (bus_wdata[7:0]),
  .irq_out   (irq_out),
  .mask_vec  (mask_vec),
  .impl_mask (impl_mask),
  .cand      (cand),
  .win_valid (win_valid),
  .win_idx   (win_idx),
  .win_prio  (win_prio),
  .evt_q     (evt_q)
);

// File: tb/pic_event_ctrl_test.sv
module pic_event_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] src_req = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_out;

  always #10 clk = ~clk;  // 50 MHz

  pic_event_ctrl uut (
    .clk(clk), .rst_n(rst_n), .src_req(src_req),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // R12 default map
  int POS [12] = '{0, 1, 2, 3, 4, 6, 8, 9, 10, 12, 14, 15};
  int FLD [12] = '{0, 1, 2, 2, 2, 3, 4, 5, 5, 6, 7, 9};
  logic [15:0] B_IMPL = 16'hD75F;
  logic [47:0] P_IMPL = {16'h00F0, 16'hFFFF, 16'hFFFF};

  logic [15:0] m_mask;
  logic [47:0] m_prio;

  function automatic logic [15:0] exp_code();
    int best = 0;
    logic [15:0] code = 16'h0;
    for (int i = 0; i < 12; i++) begin
      int p = int'((m_prio >> (FLD[i] * 4)) & 48'hF);
      if (src_req[i] && !m_mask[POS[i]] && p > best) begin
        best = p;
        code = 16'h0600 + 16'(32 * i);
      end
    end
    return code;
  endfunction

  // scoreboard
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_pend = 1'b0;

  always @(posedge clk) rd_pend <= bus_rd;

  always @(negedge clk) begin
    if (rd_pend && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (bus_rdata !== e) begin
        errors++;
        $display("FAIL %s: got %h expected %h", t, bus_rdata, e);
      end
    end
  end

  task automatic do_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    case (a[7:6])
      2'd0: m_mask[a[2]*8 +: 8] = m_mask[a[2]*8 +: 8] | (d[7:0] & B_IMPL[a[2]*8 +: 8]);
      2'd1: m_mask[a[2]*8 +: 8] = m_mask[a[2]*8 +: 8] & ~d[7:0];
      2'd2: m_prio[a[3:2]*16 +: 16] = d[15:0] & P_IMPL[a[3:2]*16 +: 16];
      default: ;
    endcase
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic do_read(input logic [7:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic chk_irq(input string t);
    logic e;
    e = (exp_code() != 16'h0);
    checks++;
    if (irq_out !== e) begin
      errors++;
      $display("FAIL %s: irq_out got %b expected %b", t, irq_out, e);
    end
  endtask

  task automatic chk_evt(input string t);
    chk_irq(t);
    do_read(8'hC0, {16'h0, exp_code()}, t);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    m_mask = B_IMPL;
    m_prio = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();

    // reset state
    chk_irq("R1 irq after reset");
    do_read(8'h00, 32'h0000005F, "R1 bank0 masked");
    do_read(8'h44, 32'h000000D7, "R1 bank1 masked");
    do_read(8'h84, 32'h0, "R1 prio reg1 zero");
    do_read(8'hC0, 32'h0, "R1 R10 event zero");

    // unused bits and fields
    do_write(8'h88, 32'hFFFF_FFFF);
    do_read(8'h88, 32'h000000F0, "R5 prio reg2 unused fields");
    do_write(8'h00, 32'h0000_00FF);
    do_read(8'h00, 32'h0000005F, "R5 bank0 unused mask bits");
    do_write(8'h88, 32'h0);
    do_write(8'h80, 32'h0000_4321);
    do_read(8'h80, 32'h00004321, "R4 prio reg0 readback");
    do_write(8'h80, 32'h0);

    // priority zero blocks
    src_req = 12'h001;
    do_write(8'h40, 32'h01);
    settle();
    chk_evt("R7 zero priority not forwarded");

    do_write(8'h80, 32'h0003);
    settle();
    chk_evt("R6 R8 source0 forwarded");

    // group field 2 covers sources 2,3,4
    do_write(8'h80, 32'h0503);
    do_write(8'h40, 32'h08);
    src_req = 12'h01D;
    settle();
    chk_evt("R11 group field drives source3");
    do_write(8'h40, 32'h04);
    settle();
    chk_evt("R9 tie goes to source2");
    do_read(8'h00, 32'h00000052, "R3 clear leaves zero bits");

    do_write(8'h00, 32'h04);
    settle();
    do_read(8'h40, 32'h00000056, "R2 set leaves zero bits");
    chk_evt("R2 masked source2 drops out");

    // higher priority in bank1, same cycle as request change
    src_req = 12'h219;
    do_write(8'h84, 32'h0F00);
    do_write(8'h44, 32'h10);
    settle();
    chk_evt("R8 source9 highest priority");

    do_write(8'h80, 32'h0F03);
    settle();
    chk_evt("R9 R11 group ties with source9");

    do_write(8'h04, 32'h10);
    settle();
    chk_evt("R2 source9 masked again");

    src_req = 12'h0;
    settle();
    chk_evt("R10 no candidate");
    chk_irq("R6 irq low when idle");

    settle();
    finish_run();
  end
endmodule